// File: doc/BRIEF.md
# Interrupt and Status Register Unit

This unit keeps the interrupt side of a SCSI protocol controller: a status byte that holds the interrupt-pending flag, the terminal-count flag and the current phase code, an interrupt-reason byte, a sequence-step counter and a FIFO-flags field. It drives one level interrupt line. Internal engines pulse event inputs such as selected, function complete, bus service and disconnect. Each pulse ORs its reason bit into the reason byte and raises the interrupt. A host command can also raise it: a bus reset or a message-accepted command.

Host software reads the reason byte to service the interrupt. That read returns the latched byte. It then clears the reason byte, the terminal-count flag and the sequence step, and drops the interrupt line. A command completion that arrives while an interrupt is still pending is not reported at once. It is parked in a one-entry slot and reported on the servicing read. This way a completion never overwrites an interrupt the host has not yet seen.

Registers by address: 0 status (read), 1 reason (read) and command (write), 2 step (read), 3 flags (read), 4 configuration (read/write). Any other address reads 0.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status, reason, step, flags and done_stat_o are 0, configuration (address 4) reads 8'h07, and irq_o is low.
- R2: A pulse on ev_sel_i, ev_fc_i, ev_bs_i or ev_dc_i ORs reason bit 0, 3, 4 or 5 respectively into the reason byte, one cycle later. It also sets status bit 7 and irq_o. Bits already set are kept until the reason byte is read.
- R3: With rd_i high at address 1, rdata_o shows the reason byte in the same cycle. After that clock edge the reason byte is 0, status bits 7 (pending) and 4 (terminal count) are 0, the step is 0 and irq_o is low. Status bits 2:0 are kept.
- R4: When done_i is high while the interrupt is pending, done_stat_i is stored in the deferred slot. Status, reason, irq_o and done_stat_o stay unchanged.
- R5: A reason-byte read while a completion is deferred reports that completion at the same edge. Status becomes 8'h93 (pending, terminal count, phase 3'b011), the reason byte becomes 8'h10, irq_o is high and done_stat_o takes the stored byte.
- R6: When done_i is high and no interrupt is pending, the completion is reported one cycle later, with the same register values as in R5 and done_stat_o equal to done_stat_i.
- R7: Writing a command byte whose low 7 bits are 7'h03 to address 1 sets reason bit 7 and raises the interrupt. It has no effect when configuration bit 6 is set.
- R8: Command 7'h12 (message accepted) sets reason bit 5, clears the step and the flags, and raises the interrupt.
- R9: Command 7'h44 (enable reselection) clears the reason byte and leaves irq_o and the status byte unchanged.
- R10: An event arriving in the same cycle as a reason-byte read is applied after the clear. Its reason bit is set and irq_o is high afterwards.
- R11: A pulse on tc_set_i sets status bit 4 without raising the interrupt. A write to address 4 stores the configuration byte.
- R12: step_ld_i loads step_i into the step register, and flags_ld_i loads flags_i into the flags register. Each is readable one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe (side effect at address 1 only) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| ev_sel_i | input | 1 | Selected event |
| ev_fc_i | input | 1 | Function-complete event |
| ev_bs_i | input | 1 | Bus-service event |
| ev_dc_i | input | 1 | Disconnect event |
| tc_set_i | input | 1 | Terminal count reached |
| step_ld_i | input | 1 | Load sequence step |
| step_i | input | 3 | Sequence step value |
| flags_ld_i | input | 1 | Load FIFO flags |
| flags_i | input | 5 | FIFO flags value |
| done_i | input | 1 | Command completion event |
| done_stat_i | input | 8 | Completion status byte |
| done_stat_o | output | 8 | Last reported completion status |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational, so it is due in the same cycle as the address. The bench samples it 1 ns after driving it on a falling edge, before the next rising edge. Every register effect of an event, command, completion or servicing read is due at the first rising edge after the stimulus. The bench drives stimulus on a falling edge, removes it on the next falling edge and samples there, exactly one register stage later. A deferred completion shows up only at the edge of the read that releases it, and the bench checks that nothing moved before that read.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int DW = 8;

  localparam int A_STAT  = 0;
  localparam int A_RSN   = 1;
  localparam int A_STEP  = 2;
  localparam int A_FLAGS = 3;
  localparam int A_CFG   = 4;
  localparam int NREG    = 5;

  localparam int RSN_SEL = 0;
  localparam int RSN_FC  = 3;
  localparam int RSN_BS  = 4;
  localparam int RSN_DC  = 5;
  localparam int RSN_RST = 7;

  localparam int ST_INT = 7;
  localparam int ST_TC  = 4;

  localparam int CFG_NORST = 6;
  localparam logic [DW-1:0] CFG_RST = 8'h07;
  localparam logic [2:0]    PH_STATUS = 3'b011;

  localparam logic [6:0] CMD_BUSRST  = 7'h03;
  localparam logic [6:0] CMD_MSGACC  = 7'h12;
  localparam logic [6:0] CMD_ENRESEL = 7'h44;

  typedef struct packed {
    logic bus_rst;
    logic msg_acc;
    logic en_resel;
    logic cfg_wr;
  } cmd_t;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output cmd_t              cmd_o
);
  logic cmd_wr;
  assign cmd_wr = wr_i && (addr_i == ADDR_W'(A_RSN));

  always_comb begin
    cmd_o          = '0;
    cmd_o.bus_rst  = cmd_wr && (wdata_i[6:0] == CMD_BUSRST);
    cmd_o.msg_acc  = cmd_wr && (wdata_i[6:0] == CMD_MSGACC);
    cmd_o.en_resel = cmd_wr && (wdata_i[6:0] == CMD_ENRESEL);
    cmd_o.cfg_wr   = wr_i && (addr_i == ADDR_W'(A_CFG));
  end
endmodule

// File: rtl/irq_defer_slot.sv
module irq_defer_slot #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          release_i,
  input  logic [SW-1:0] stat_i,
  output logic          valid_o,
  output logic [SW-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      stat_o  <= '0;
    end else begin
      if (capture_i) begin
        valid_o <= 1'b1;
        stat_o  <= stat_i;
      end else if (release_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  a_r4_capture_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (valid_o && stat_o == $past(stat_i)));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int ADDR_W = 3,
  parameter int NR     = 5,
  parameter int W      = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NR-1:0][W-1:0] regs_i,
  output logic [W-1:0]         rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NR; k++) begin
      if (addr_i == ADDR_W'(k)) rdata_o = regs_i[k];
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int STEP_W  = 3,
  parameter int FLAGS_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               ev_sel_i,
  input  logic               ev_fc_i,
  input  logic               ev_bs_i,
  input  logic               ev_dc_i,
  input  logic               tc_set_i,
  input  logic               step_ld_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic               flags_ld_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic               done_i,
  input  logic [DW-1:0]      done_stat_i,
  output logic [DW-1:0]      done_stat_o,
  output logic               irq_o
);
  localparam int STEP_PAD  = DW - STEP_W;
  localparam int FLAGS_PAD = DW - FLAGS_W;

  logic [DW-1:0]      status_q, rsn_q, cfg_q, done_q;
  logic [STEP_W-1:0]  step_q;
  logic [FLAGS_W-1:0] flags_q;

  logic [DW-1:0]      status_n, rsn_n, cfg_n, done_n;
  logic [STEP_W-1:0]  step_n;
  logic [FLAGS_W-1:0] flags_n;

  cmd_t          cmd;
  logic          rd_rsn, def_valid, def_release, def_capture;
  logic [DW-1:0] def_stat, ev_bits;

  irq_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .cmd_o(cmd)
  );

  assign rd_rsn      = rd_i && (addr_i == ADDR_W'(A_RSN));
  assign def_release = rd_rsn && def_valid;

  always_comb begin
    ev_bits          = '0;
    ev_bits[RSN_SEL] = ev_sel_i;
    ev_bits[RSN_FC]  = ev_fc_i;
    ev_bits[RSN_BS]  = ev_bs_i;
    ev_bits[RSN_DC]  = ev_dc_i;
  end

  always_comb begin
    status_n    = status_q;
    rsn_n       = rsn_q;
    cfg_n       = cfg_q;
    done_n      = done_q;
    step_n      = step_q;
    flags_n     = flags_q;
    def_capture = 1'b0;
    // servicing read clears first
    if (rd_rsn) begin
      rsn_n           = '0;
      status_n[ST_TC]  = 1'b0;
      status_n[ST_INT] = 1'b0;
      step_n          = '0;
    end
    if (cmd.cfg_wr) cfg_n = wdata_i;
    if (cmd.en_resel) rsn_n = '0;
    if (cmd.msg_acc) begin
      rsn_n[RSN_DC]    = 1'b1;
      step_n           = '0;
      flags_n          = '0;
      status_n[ST_INT] = 1'b1;
    end
    if (cmd.bus_rst && !cfg_q[CFG_NORST]) begin
      rsn_n[RSN_RST]   = 1'b1;
      status_n[ST_INT] = 1'b1;
    end
    if (def_release) begin
      status_n[2:0]    = PH_STATUS;
      status_n[ST_TC]  = 1'b1;
      status_n[ST_INT] = 1'b1;
      rsn_n[RSN_BS]    = 1'b1;
      done_n           = def_stat;
    end
    // events land after the clear
    rsn_n = rsn_n | ev_bits;
    if (|ev_bits) status_n[ST_INT] = 1'b1;
    if (tc_set_i) status_n[ST_TC] = 1'b1;
    if (step_ld_i) step_n = step_i;
    if (flags_ld_i) flags_n = flags_i;
    if (done_i) begin
      if (status_n[ST_INT]) begin
        def_capture = 1'b1;
      end else begin
        status_n[2:0]    = PH_STATUS;
        status_n[ST_TC]  = 1'b1;
        status_n[ST_INT] = 1'b1;
        rsn_n[RSN_BS]    = 1'b1;
        done_n           = done_stat_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      rsn_q    <= '0;
      cfg_q    <= CFG_RST;
      done_q   <= '0;
      step_q   <= '0;
      flags_q  <= '0;
    end else begin
      status_q <= status_n;
      rsn_q    <= rsn_n;
      cfg_q    <= cfg_n;
      done_q   <= done_n;
      step_q   <= step_n;
      flags_q  <= flags_n;
    end
  end

  irq_defer_slot #(.SW(DW)) u_defer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .capture_i(def_capture), .release_i(def_release),
    .stat_i(done_stat_i), .valid_o(def_valid), .stat_o(def_stat)
  );

  logic [NREG-1:0][DW-1:0] regs;
  always_comb begin
    regs          = '0;
    regs[A_STAT]  = status_q;
    regs[A_RSN]   = rsn_q;
    regs[A_STEP]  = {{STEP_PAD{1'b0}}, step_q};
    regs[A_FLAGS] = {{FLAGS_PAD{1'b0}}, flags_q};
    regs[A_CFG]   = cfg_q;
  end

  irq_read_mux #(.ADDR_W(ADDR_W), .NR(NREG), .W(DW)) u_mux (
    .addr_i(addr_i), .regs_i(regs), .rdata_o(rdata_o)
  );

  assign irq_o       = status_q[ST_INT];
  assign done_stat_o = done_q;

  logic quiet;
  assign quiet = !(|ev_bits) && !done_i && !wr_i && !tc_set_i;

  a_r2_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_rsn && !cmd.en_resel) |=> ((rsn_q & $past(rsn_q)) == $past(rsn_q)));
  a_r3_read_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rsn && !def_valid && quiet) |=> (!irq_o && rsn_q == '0));
  a_r4_no_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && done_i && !rd_rsn) |=> (done_q == $past(done_q)));
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rsn && def_valid) |=> (irq_o && status_q[ST_TC] && rsn_q[RSN_BS]));
  a_r7_bus_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.bus_rst && !cfg_q[CFG_NORST]) |=> (irq_o && rsn_q[RSN_RST]));
  a_r10_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rsn && ev_fc_i) |=> rsn_q[RSN_FC]);
endmodule

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_sel = 0, ev_fc = 0, ev_bs = 0, ev_dc = 0, tc_set = 0;
  logic       step_ld = 0, flags_ld = 0, done = 0;
  logic [2:0] step_v = '0;
  logic [4:0] flags_v = '0;
  logic [7:0] done_stat = '0;
  logic [7:0] done_stat_out;
  logic       irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_status_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ev_sel_i(ev_sel), .ev_fc_i(ev_fc),
    .ev_bs_i(ev_bs), .ev_dc_i(ev_dc), .tc_set_i(tc_set), .step_ld_i(step_ld),
    .step_i(step_v), .flags_ld_i(flags_ld), .flags_i(flags_v), .done_i(done),
    .done_stat_i(done_stat), .done_stat_o(done_stat_out), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd = 1'b0;
    #1 v = rdata;
  endtask

  task automatic set_ev(input logic [3:0] m);
    ev_sel = m[0]; ev_fc = m[1]; ev_bs = m[2]; ev_dc = m[3];
  endtask

  task automatic pulse_ev(input logic [3:0] m);
    @(negedge clk); set_ev(m);
    @(negedge clk); set_ev(4'b0);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_rsn(input logic [3:0] m, output logic [7:0] v);
    @(negedge clk); addr = 3'd1; rd = 1'b1; set_ev(m);
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; set_ev(4'b0);
  endtask

  function automatic logic [7:0] ev_byte(input logic [3:0] m);
    return {2'b00, m[3], m[2], m[1], 2'b00, m[0]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin peek(3'(a), v); chk("R1 reg zero", v, 8'h00); end
    peek(3'd4, v); chk("R1 config", v, 8'h07);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 done_stat", done_stat_out, 8'h00);

    // R2/R3 sweep over all event combinations
    for (int m = 1; m < 16; m++) begin
      pulse_ev(4'(m));
      peek(3'd1, v); chk("R2 reason bits", v, ev_byte(4'(m)));
      peek(3'd0, v); chk("R2 pending", v, 8'h80);
      chk("R2 irq", {7'b0, irq}, 8'h01);
      pulse_ev(4'b0010);
      peek(3'd1, v); chk("R2 accumulate", v, ev_byte(4'(m)) | 8'h08);
      rd_rsn(4'b0, r); chk("R3 read value", r, ev_byte(4'(m)) | 8'h08);
      peek(3'd1, v); chk("R3 reason cleared", v, 8'h00);
      peek(3'd0, v); chk("R3 status cleared", v, 8'h00);
      chk("R3 irq low", {7'b0, irq}, 8'h00);
    end

    // R11 terminal count and config
    @(negedge clk); tc_set = 1; @(negedge clk); tc_set = 0;
    peek(3'd0, v); chk("R11 tc", v, 8'h10);
    chk("R11 no irq", {7'b0, irq}, 8'h00);
    wr_reg(3'd4, 8'h47);
    peek(3'd4, v); chk("R11 config", v, 8'h47);

    // R12 step and flags loads; R3 read clears step and tc
    @(negedge clk); step_ld = 1; step_v = 3'd5; flags_ld = 1; flags_v = 5'h1A;
    @(negedge clk); step_ld = 0; flags_ld = 0;
    peek(3'd2, v); chk("R12 step", v, 8'h05);
    peek(3'd3, v); chk("R12 flags", v, 8'h1A);
    rd_rsn(4'b0, r);
    peek(3'd2, v); chk("R3 step cleared", v, 8'h00);
    peek(3'd0, v); chk("R3 tc cleared", v, 8'h00);

    // R7 bus reset disabled by config bit 6
    wr_reg(3'd1, 8'h03);
    peek(3'd1, v); chk("R7 disabled reason", v, 8'h00);
    chk("R7 disabled irq", {7'b0, irq}, 8'h00);
    wr_reg(3'd4, 8'h07);
    wr_reg(3'd1, 8'h83);
    peek(3'd1, v); chk("R7 reason", v, 8'h80);
    chk("R7 irq", {7'b0, irq}, 8'h01);
    rd_rsn(4'b0, r);

    // R8 message accepted
    @(negedge clk); step_ld = 1; step_v = 3'd6; flags_ld = 1; flags_v = 5'h07;
    @(negedge clk); step_ld = 0; flags_ld = 0;
    wr_reg(3'd1, 8'h12);
    peek(3'd1, v); chk("R8 reason", v, 8'h20);
    peek(3'd2, v); chk("R8 step", v, 8'h00);
    peek(3'd3, v); chk("R8 flags", v, 8'h00);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    rd_rsn(4'b0, r);

    // R9 enable reselection
    pulse_ev(4'b0010);
    wr_reg(3'd1, 8'h44);
    peek(3'd1, v); chk("R9 reason cleared", v, 8'h00);
    peek(3'd0, v); chk("R9 status kept", v, 8'h80);
    chk("R9 irq kept", {7'b0, irq}, 8'h01);
    rd_rsn(4'b0, r); chk("R9 read zero", r, 8'h00);
    chk("R9 irq low after read", {7'b0, irq}, 8'h00);

    // R6 immediate completion
    @(negedge clk); done = 1; done_stat = 8'h02;
    @(negedge clk); done = 0;
    peek(3'd0, v); chk("R6 status", v, 8'h93);
    peek(3'd1, v); chk("R6 reason", v, 8'h10);
    chk("R6 irq", {7'b0, irq}, 8'h01);
    chk("R6 done_stat", done_stat_out, 8'h02);
    rd_rsn(4'b0, r); chk("R6 read", r, 8'h10);
    peek(3'd0, v); chk("R3 phase kept", v, 8'h03);

    // R4 deferral, R5 release
    pulse_ev(4'b0010);
    @(negedge clk); done = 1; done_stat = 8'h55;
    @(negedge clk); done = 0;
    peek(3'd0, v); chk("R4 status unchanged", v, 8'h83);
    peek(3'd1, v); chk("R4 reason unchanged", v, 8'h08);
    chk("R4 done_stat unchanged", done_stat_out, 8'h02);
    rd_rsn(4'b0, r); chk("R5 read value", r, 8'h08);
    peek(3'd0, v); chk("R5 status", v, 8'h93);
    peek(3'd1, v); chk("R5 reason", v, 8'h10);
    chk("R5 irq", {7'b0, irq}, 8'h01);
    chk("R5 done_stat", done_stat_out, 8'h55);
    rd_rsn(4'b0, r); chk("R5 second read", r, 8'h10);
    chk("R5 irq low", {7'b0, irq}, 8'h00);

    // R10 events in the read cycle survive the clear
    for (int m = 1; m < 16; m++) begin
      pulse_ev(4'b0001);
      rd_rsn(4'(m), r); chk("R10 read old", r, 8'h01);
      peek(3'd1, v); chk("R10 reason", v, ev_byte(4'(m)));
      chk("R10 irq", {7'b0, irq}, 8'h01);
      rd_rsn(4'b0, r);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule